// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines and raises one interrupt output toward a processor. Priority is fixed: line 0 ranks highest. Software drives the block over a byte-wide register bus with three addresses: a command port, a data port and a trigger-mode register. Reads are combinational from the address. Writes take effect at the clock edge where `bus_wr` is high.

The block holds three registers: pending requests (IRR), in-service lines (ISR) and the mask (IMR). Software sets it up with a short run of writes. First a command word with bit 4 set starts setup. The following data-port writes then supply the vector base, the cascade setting and the mode word. After setup, a data-port write loads the mask.

When the processor pulses `int_ack`, the block answers one cycle later with an 8-bit vector and marks the winning line in service. Later command words end service for a line. They also choose which register the command port reads back. An acknowledge that finds no eligible request returns the vector for line 7 and marks nothing.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `int_out` and `vec_valid` are 0, the command port reads 0 (IRR selected), the data port reads 0 (IMR clear) and `casc_cfg` reads 0x04.
- R2: A command write with bit 4 set starts setup. It clears IRR, ISR and IMR, selects IRR for readback and turns automatic end-of-service off. The next data-port writes are taken as setup words: first the vector base, then the cascade word, then the mode word. Only after that does a data-port write load IMR.
- R3: When `int_ack` is high at an edge, `vec_valid` is high for the following cycle. `vec_out` then holds the vector base plus the index of the line that won at that edge. That line's ISR bit is set and, for an edge-mode line, its IRR bit is cleared.
- R4: `int_out` is high exactly when some unmasked IRR bit has a lower index than every set ISR bit. Among eligible lines the lowest index wins.
- R5: Masked lines still set their IRR bit but never raise `int_out`. A data-port read returns IMR, and writing 0xFF masks every line.
- R6: A command write of 0x0B makes command-port reads return ISR. A command write of 0x0A makes them return IRR. The choice persists until changed.
- R7: A command write of 0x60+n (n = 0..7) clears ISR bit n and no other bit.
- R8: A command write of 0x20 clears the lowest-index set ISR bit.
- R9: If bit 1 of the mode word was 1, an acknowledge leaves ISR unchanged.
- R10: An acknowledge while `int_out` is low returns the vector base plus 7 and leaves ISR unchanged, even when line 7 is masked. This includes the case where a request was dropped before the acknowledge.
- R11: The trigger register (address 2) holds one bit per line: 1 means level, 0 means edge. Bits in the reserved mask (default 0x07) read as 0 and stay edge. An edge-mode IRR bit sets on a rising input and clears on acknowledge. A level-mode IRR bit follows the input, one cycle late.
- R12: In the setup-start word, bit 1 = 1 skips the cascade word and bit 0 = 0 skips the mode word, leaving automatic end-of-service off.
- R13: `casc_cfg` shows the cascade word: the full byte on a master build, and only its low 3 bits on a slave build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | 0 command port, 1 data port, 2 trigger register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Acknowledge pulse |
| vec_out | output | 8 | Vector delivered after an acknowledge |
| vec_valid | output | 1 | `vec_out` is valid this cycle |
| casc_cfg | output | 8 | Cascade setting from setup |

## Verification
The bench builds the master variant with the default reserved mask of 0x07. With that mask, lines 0 to 2 stay edge-triggered while lines 3 to 7 can be switched to level, so both capture styles are exercised in the same run. The random phase drives level requests on the upper five lines under random masks. It compares the interrupt output and the delivered vector with a priority search written in the bench. The directed cases cover nested service, both kinds of end-of-service, spurious delivery and the shortened setup runs.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int IRQ_LINES = 8;
  localparam int IDX_W     = $clog2(IRQ_LINES);
  localparam int BUS_W     = 8;

  typedef logic [IRQ_LINES-1:0] line_vec_t;
  typedef logic [IDX_W-1:0]     line_idx_t;
  typedef logic [BUS_W-1:0]     bus_word_t;

  localparam logic [1:0] ADR_CMD  = 2'd0;
  localparam logic [1:0] ADR_DATA = 2'd1;
  localparam logic [1:0] ADR_TRIG = 2'd2;

  typedef enum logic [1:0] {CFG_RUN, CFG_BASE, CFG_CASC, CFG_MODE} cfg_state_t;

  typedef struct packed {
    logic      hit;
    line_idx_t idx;
  } pick_t;

  // Walk from highest priority; an in-service line blocks itself and below.
  function automatic pick_t pick_winner(line_vec_t irr, line_vec_t imr, line_vec_t isr);
    pick_t r;
    logic  blocked;
    r = '0;
    blocked = 1'b0;
    for (int i = 0; i < IRQ_LINES; i++) begin
      if (!blocked && !r.hit) begin
        if (isr[i]) blocked = 1'b1;
        else if (irr[i] && !imr[i]) begin
          r.hit = 1'b1;
          r.idx = line_idx_t'(i);
        end
      end
    end
    return r;
  endfunction

  function automatic line_idx_t lowest_set(line_vec_t v);
    line_idx_t r;
    r = '0;
    for (int i = IRQ_LINES - 1; i >= 0; i--)
      if (v[i]) r = line_idx_t'(i);
    return r;
  endfunction

  function automatic line_vec_t onehot(line_idx_t idx);
    return line_vec_t'(1) << idx;
  endfunction

  function automatic bus_word_t vector_for(bus_word_t base, line_idx_t idx);
    return base + bus_word_t'(idx);
  endfunction

  function automatic logic is_setup_start(bus_word_t w);
    return w[4];
  endfunction

  function automatic logic is_read_sel(bus_word_t w);
    return (w[4:3] == 2'b01) && w[1];
  endfunction

  function automatic logic is_spec_eoi(bus_word_t w);
    return (w[4:3] == 2'b00) && (w[7:5] == 3'b011);
  endfunction

  function automatic logic is_lowest_eoi(bus_word_t w);
    return (w[4:3] == 2'b00) && (w[7:5] == 3'b001);
  endfunction
endpackage

// File: rtl/irq_capture.sv
module irq_capture
  import prio_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  line_vec_t irq_in,
  input  line_vec_t lvl_mode,
  input  line_vec_t ack_clr,
  output line_vec_t irr
);
  line_vec_t prev_q;
  line_vec_t rise;
  line_vec_t irr_next;

  assign rise = irq_in & ~prev_q;

  for (genvar g = 0; g < IRQ_LINES; g++) begin : g_line
    assign irr_next[g] = lvl_mode[g] ? irq_in[g]
                                     : ((irr[g] & ~ack_clr[g]) | rise[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr    <= '0;
    end else begin
      prev_q <= irq_in;
      irr    <= flush ? '0 : irr_next;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import prio_irq_pkg::*;
(
  input  line_vec_t irr,
  input  line_vec_t imr,
  input  line_vec_t isr,
  output logic      req,
  output line_idx_t win_idx
);
  pick_t pick;
  assign pick    = pick_winner(irr, imr, isr);
  assign req     = pick.hit;
  assign win_idx = pick.idx;
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import prio_irq_pkg::*;
#(
  parameter bit        IS_MASTER = 1'b1,
  parameter line_vec_t TRIG_RSVD = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  bus_word_t  bus_wdata,
  input  logic       int_ack,
  input  logic       req,
  input  line_idx_t  win_idx,
  output logic       init_start,
  output logic       ack_real,
  output logic       ack_spur,
  output logic       eoi_spec,
  output logic       eoi_low,
  output line_vec_t  imr,
  output line_vec_t  trig_lvl,
  output bus_word_t  vec_base,
  output bus_word_t  casc_cfg,
  output logic       aeoi,
  output logic       rsel_isr,
  output line_vec_t  isr
);
  localparam bus_word_t CASC_DEFAULT = IS_MASTER ? 8'h04 : 8'h02;

  cfg_state_t st;
  logic       need_casc, need_mode;
  bus_word_t  casc_q;
  logic       cmd_wr, data_wr, trig_wr;
  line_vec_t  isr_set, isr_clr;

  assign cmd_wr  = bus_wr && (bus_addr == ADR_CMD);
  assign data_wr = bus_wr && (bus_addr == ADR_DATA);
  assign trig_wr = bus_wr && (bus_addr == ADR_TRIG);

  assign init_start = cmd_wr && is_setup_start(bus_wdata);
  assign eoi_spec   = cmd_wr && is_spec_eoi(bus_wdata);
  assign eoi_low    = cmd_wr && is_lowest_eoi(bus_wdata);
  assign ack_real   = int_ack && req;
  assign ack_spur   = int_ack && !req;

  assign isr_set = (ack_real && !aeoi) ? onehot(win_idx) : '0;
  assign isr_clr = eoi_spec ? onehot(line_idx_t'(bus_wdata[2:0]))
                 : (eoi_low && (isr != '0)) ? onehot(lowest_set(isr)) : '0;

  if (IS_MASTER) begin : g_master
    assign casc_cfg = casc_q;
  end else begin : g_slave
    assign casc_cfg = {5'b0, casc_q[2:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= CFG_RUN;
      need_casc <= 1'b0;
      need_mode <= 1'b0;
      imr       <= '0;
      trig_lvl  <= '0;
      vec_base  <= '0;
      casc_q    <= CASC_DEFAULT;
      aeoi      <= 1'b0;
      rsel_isr  <= 1'b0;
      isr       <= '0;
    end else if (init_start) begin
      st        <= CFG_BASE;
      need_casc <= !bus_wdata[1];
      need_mode <= bus_wdata[0];
      imr       <= '0;
      aeoi      <= 1'b0;
      rsel_isr  <= 1'b0;
      isr       <= '0;
    end else begin
      isr <= (isr & ~isr_clr) | isr_set;
      if (cmd_wr && is_read_sel(bus_wdata)) rsel_isr <= bus_wdata[0];
      if (trig_wr) trig_lvl <= bus_wdata & ~TRIG_RSVD;
      if (data_wr) begin
        unique case (st)
          CFG_RUN:  imr <= bus_wdata;
          CFG_BASE: begin
            vec_base <= bus_wdata;
            st <= need_casc ? CFG_CASC : (need_mode ? CFG_MODE : CFG_RUN);
          end
          CFG_CASC: begin
            casc_q <= bus_wdata;
            st <= need_mode ? CFG_MODE : CFG_RUN;
          end
          CFG_MODE: begin
            aeoi <= bus_wdata[1];
            st   <= CFG_RUN;
          end
          default:  st <= CFG_RUN;
        endcase
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter bit        IS_MASTER = 1'b1,
  parameter line_vec_t TRIG_RSVD = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] irq_in,
  output logic       int_out,
  input  logic       int_ack,
  output logic [7:0] vec_out,
  output logic       vec_valid,
  output logic [7:0] casc_cfg
);
  line_vec_t irr, isr, imr, trig_lvl, irr_clr;
  bus_word_t vec_base;
  line_idx_t win_idx;
  logic      req, init_start, ack_real, ack_spur, eoi_spec, eoi_low;
  logic      aeoi, rsel_isr;

  irq_ctrl_regs #(.IS_MASTER(IS_MASTER), .TRIG_RSVD(TRIG_RSVD)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .int_ack(int_ack), .req(req), .win_idx(win_idx),
    .init_start(init_start), .ack_real(ack_real), .ack_spur(ack_spur),
    .eoi_spec(eoi_spec), .eoi_low(eoi_low), .imr(imr), .trig_lvl(trig_lvl),
    .vec_base(vec_base), .casc_cfg(casc_cfg), .aeoi(aeoi),
    .rsel_isr(rsel_isr), .isr(isr)
  );

  assign irr_clr = ack_real ? onehot(win_idx) : '0;

  irq_capture u_cap (
    .clk(clk), .rst_n(rst_n), .flush(init_start), .irq_in(irq_in),
    .lvl_mode(trig_lvl), .ack_clr(irr_clr), .irr(irr)
  );

  irq_arbiter u_arb (
    .irr(irr), .imr(imr), .isr(isr), .req(req), .win_idx(win_idx)
  );

  assign int_out = req;

  always_comb begin
    unique case (bus_addr)
      ADR_CMD:  bus_rdata = rsel_isr ? isr : irr;
      ADR_DATA: bus_rdata = imr;
      ADR_TRIG: bus_rdata = trig_lvl;
      default:  bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      vec_valid <= int_ack;
      if (int_ack)
        vec_out <= ack_real ? vector_for(vec_base, win_idx)
                            : vector_for(vec_base, line_idx_t'(IRQ_LINES - 1));
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      int_ack,
  input logic      int_out,
  input bus_word_t vec_out,
  input logic      vec_valid,
  input logic      ack_real,
  input logic      ack_spur,
  input logic      init_start,
  input logic      eoi_spec,
  input logic      eoi_low,
  input logic [2:0] eoi_idx,
  input logic      aeoi,
  input line_vec_t isr,
  input line_vec_t imr,
  input line_vec_t irr,
  input bus_word_t vec_base
);
  // R4
  int_needs_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~imr) != '0));

  // R5
  full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == '1) |-> !int_out);

  // R3
  vec_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> vec_valid);

  // R3
  vec_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_ack |=> !vec_valid);

  // R10
  spurious_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_spur |=> (vec_out == $past(vec_base) + 8'(IRQ_LINES - 1)));

  // R10
  spurious_isr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_spur && !eoi_spec && !eoi_low && !init_start) |=> (isr == $past(isr)));

  // R9
  auto_eoi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_real && aeoi && !eoi_spec && !eoi_low && !init_start) |=> (isr == $past(isr)));

  // R7
  spec_eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_spec && !ack_real) |=> !isr[$past(eoi_idx)]);

  // R2
  setup_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> ((isr == '0) && (imr == '0)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .int_ack(int_ack), .int_out(int_out),
  .vec_out(vec_out), .vec_valid(vec_valid), .ack_real(ack_real),
  .ack_spur(ack_spur), .init_start(init_start), .eoi_spec(eoi_spec),
  .eoi_low(eoi_low), .eoi_idx(bus_wdata[2:0]), .aeoi(aeoi), .isr(isr),
  .imr(imr), .irr(irr), .vec_base(vec_base)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [7:0] irq_in = 8'd0;
  logic       int_out;
  logic       int_ack = 1'b0;
  logic [7:0] vec_out;
  logic       vec_valid;
  logic [7:0] casc_cfg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .int_out(int_out), .int_ack(int_ack), .vec_out(vec_out),
    .vec_valid(vec_valid), .casc_cfg(casc_cfg)
  );

  function automatic logic exp_int(logic [7:0] req, logic [7:0] msk);
    return (req & ~msk) != 8'd0;
  endfunction

  function automatic logic [7:0] exp_vec(logic [7:0] base, logic [7:0] req, logic [7:0] msk);
    logic [7:0] v;
    v = base + 8'd7;
    for (int k = 7; k >= 0; k--)
      if (req[k] && !msk[k]) v = base + 8'(k);
    return v;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a;
    bus_wdata = d;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic ack();
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] m;
    logic [7:0] q;
    logic [7:0] e;
    v = 8'($urandom(32'h1d2c3b4a));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 int_out", {7'd0, int_out}, 8'd0);
    chk("R1 vec_valid", {7'd0, vec_valid}, 8'd0);
    rd(2'd0, v); chk("R1 cmd read", v, 8'h00);
    rd(2'd1, v); chk("R1 imr read", v, 8'h00);
    chk("R1 casc", casc_cfg, 8'h04);

    // R2 setup sequence
    wr(2'd0, 8'h11); wr(2'd1, 8'h20); wr(2'd1, 8'h0C); wr(2'd1, 8'h01);
    chk("R13 casc after setup", casc_cfg, 8'h0C);
    rd(2'd1, v); chk("R2 imr untouched by setup words", v, 8'h00);
    wr(2'd1, 8'h5A);
    rd(2'd1, v); chk("R2 imr loads after setup", v, 8'h5A);
    wr(2'd1, 8'h00);

    // R11 edge capture on line 3
    irq_in = 8'h08; tick();
    rd(2'd0, v); chk("R11 edge sets irr", v, 8'h08);
    chk("R4 int raised", {7'd0, int_out}, 8'd1);
    ack();
    chk("R3 vec_valid", {7'd0, vec_valid}, 8'd1);
    chk("R3 vector", vec_out, 8'h23);
    rd(2'd0, v); chk("R11 edge irr cleared by ack", v, 8'h00);
    tick();
    chk("R3 vec_valid one cycle", {7'd0, vec_valid}, 8'd0);
    wr(2'd0, 8'h0B);
    rd(2'd0, v); chk("R6 isr selected", v, 8'h08);
    irq_in = 8'h00; tick(); tick();
    rd(2'd0, v); chk("R6 selection persists", v, 8'h08);
    irq_in = 8'h08; tick();
    wr(2'd0, 8'h0A);
    rd(2'd0, v); chk("R11 new edge sets irr", v, 8'h08);
    chk("R4 same line in service blocks", {7'd0, int_out}, 8'd0);
    wr(2'd0, 8'h63);
    chk("R7 eoi frees line", {7'd0, int_out}, 8'd1);
    ack();
    chk("R3 vector again", vec_out, 8'h23);
    wr(2'd0, 8'h63);
    irq_in = 8'h00; tick();

    // R11 trigger register with reserved bits
    wr(2'd2, 8'hFF);
    rd(2'd2, v); chk("R11 reserved bits read zero", v, 8'hF8);

    // R4 nesting, R7/R8 end of service (level lines)
    wr(2'd0, 8'h0B);
    irq_in = 8'h20; tick();
    ack();
    chk("R3 level vector", vec_out, 8'h25);
    irq_in = 8'h60; tick(); tick();
    chk("R4 lower line blocked", {7'd0, int_out}, 8'd0);
    irq_in = 8'h70; tick(); tick();
    chk("R4 higher line preempts", {7'd0, int_out}, 8'd1);
    ack();
    chk("R4 winner vector", vec_out, 8'h24);
    rd(2'd0, v); chk("R4 nested isr", v, 8'h30);
    wr(2'd0, 8'h20);
    rd(2'd0, v); chk("R8 lowest cleared", v, 8'h20);
    chk("R8 line 4 eligible again", {7'd0, int_out}, 8'd1);
    ack();
    rd(2'd0, v); chk("R7 isr before", v, 8'h30);
    wr(2'd0, 8'h65);
    rd(2'd0, v); chk("R7 only bit 5 cleared", v, 8'h10);
    wr(2'd0, 8'h64);
    rd(2'd0, v); chk("R7 bit 4 cleared", v, 8'h00);
    irq_in = 8'h00; tick();

    // R5 masking
    wr(2'd1, 8'hFF);
    irq_in = 8'hF8; tick(); tick();
    chk("R5 masked no int", {7'd0, int_out}, 8'd0);
    wr(2'd0, 8'h0A);
    rd(2'd0, v); chk("R5 masked irr set", v, 8'hF8);
    rd(2'd1, v); chk("R5 imr read", v, 8'hFF);

    // R10 spurious
    irq_in = 8'h00; tick(); tick();
    ack();
    chk("R10 spurious masked vector", vec_out, 8'h27);
    wr(2'd0, 8'h0B);
    rd(2'd0, v); chk("R10 isr untouched", v, 8'h00);
    wr(2'd1, 8'h00);
    irq_in = 8'h10; tick(); tick();
    chk("R10 request seen", {7'd0, int_out}, 8'd1);
    irq_in = 8'h00; tick();
    ack();
    chk("R10 withdrawn vector", vec_out, 8'h27);
    rd(2'd0, v); chk("R10 withdrawn isr", v, 8'h00);

    // random level requests on lines 3..7
    for (int it = 0; it < 40; it++) begin
      m = 8'($urandom);
      q = 8'($urandom) & 8'hF8;
      wr(2'd1, m);
      irq_in = q; tick();
      chk("R4 random int", {7'd0, int_out}, {7'd0, exp_int(q, m)});
      if (exp_int(q, m)) begin
        ack();
        e = exp_vec(8'h20, q, m);
        chk("R4 random vector", vec_out, e);
        rd(2'd0, v); chk("R3 random isr", v, 8'h01 << (e - 8'h20));
        wr(2'd0, 8'h20);
        rd(2'd0, v); chk("R8 random clear", v, 8'h00);
      end
      irq_in = 8'h00; tick();
    end

    // R9 automatic end of service, R2 clear by new setup
    wr(2'd1, 8'h33);
    wr(2'd0, 8'h11); wr(2'd1, 8'h40); wr(2'd1, 8'h06); wr(2'd1, 8'h03);
    rd(2'd1, v); chk("R2 setup clears imr", v, 8'h00);
    rd(2'd0, v); chk("R2 read select back to irr", v, 8'h00);
    irq_in = 8'h08; tick();
    ack();
    chk("R9 vector", vec_out, 8'h43);
    wr(2'd0, 8'h0B);
    rd(2'd0, v); chk("R9 isr stays clear", v, 8'h00);
    irq_in = 8'h00; tick();

    // R12 shortened setup runs
    wr(2'd0, 8'h13); wr(2'd1, 8'h80); wr(2'd1, 8'h00); wr(2'd1, 8'h11);
    chk("R12 cascade word skipped", casc_cfg, 8'h06);
    rd(2'd1, v); chk("R12 imr after short setup", v, 8'h11);
    wr(2'd0, 8'h12); wr(2'd1, 8'h60); wr(2'd1, 8'h22);
    rd(2'd1, v); chk("R12 mode word skipped", v, 8'h22);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h0B);
    irq_in = 8'h08; tick();
    ack();
    chk("R12 base from short setup", vec_out, 8'h63);
    rd(2'd0, v); chk("R12 auto end off", v, 8'h08);
    irq_in = 8'h00; tick();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule